// File: doc/BRIEF.md
# TLB Random Replacement Index Generator

This block supplies the entry number that a write-random operation uses to pick a victim slot in a translation lookaside buffer. It holds a small down-counter that moves through the entries not reserved for the operating system. When it reaches the reserved boundary, it wraps back to the topmost entry.

The lowest entry it may reach is set by the wired count, which is driven from outside. The highest entry is always the last slot of the buffer. A free-running linear feedback shift register withholds some decrements, so the selected slot is harder to predict and lock-step livelock is avoided. Writing the wired count sends the counter back to the top slot.

The current index is available directly for the write path. A zero-extended word view is provided for software reads.

Top module: `tlb_rand_idx`

## Requirements
- R1: With the default 4-bit index (16 entries, top entry 15), synchronous active-high reset loads the index with 15.
- R2: On a rising edge with no wired write, a wired value below 15, no hold from the shift register and an index above the wired value, the index becomes the index minus one.
- R3: On a rising edge with no wired write, a wired value below 15 and no hold, an index at or below the wired value becomes 15 instead of going lower.
- R4: The shift register is 8 bits wide and loads 0xA5 on reset. Each cycle it shifts left, taking as its new bit 0 the XOR of its bits 7, 5, 4 and 3. On an edge where its current bit 0 is 1, with no wired write and a wired value below 15, the index keeps its value.
- R5: A wired write strobe high at a rising edge loads 15 into the index, overriding decrement, hold and wrap.
- R6: While the wired value is 15 or more, each rising edge sets the index to 15.
- R7: The 32-bit read view carries the index in bits 3:0 and zeros in bits 31:4, and it follows the index register with no added delay.
- R8: The wired value applies as the limit at each edge without a strobe. An index found below a newly lowered or raised limit wraps to 15 on its next unheld step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wired_i | input | IDX_W (4) | Count of reserved low entries, the lower limit |
| wired_we_i | input | 1 | Strobe marking a write of the wired count |
| idx_o | output | IDX_W (4) | Current replacement index |
| rd_view_o | output | READ_W (32) | Zero-extended word view of the index |

## Verification
The bench builds the block with its defaults: a 4-bit index, an 8-bit shift register with feedback from bits 7, 5, 4 and 3, seed 0xA5, gating enabled and a 32-bit view. With only sixteen entries, random wired values regularly fall on 14 and 15, wraps happen every few cycles, and limits often move above or below the live index. The bench keeps its own copy of the shift register from the seed and taps, so every held step is predicted exactly instead of being inferred.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;

   // Action chosen for the index register on the next edge
   typedef enum logic [1:0] {
      ACT_TOP  = 2'd0,
      ACT_HOLD = 2'd1,
      ACT_DEC  = 2'd2
   } rand_act_e;

endpackage

// File: rtl/tlb_rand_lfsr.sv
module tlb_rand_lfsr #(
   parameter int unsigned       W    = 8,
   parameter logic [W-1:0]      TAPS = 8'hB8,
   parameter logic [W-1:0]      SEED = 8'hA5
) (
   input  logic clk,
   input  logic rst,
   output logic gate_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("tlb_rand_lfsr: W must be at least 2");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("tlb_rand_lfsr: SEED must be nonzero");
      end
      if (TAPS == '0) begin : g_bad_taps
         $error("tlb_rand_lfsr: TAPS must be nonzero");
      end
   endgenerate

   logic [W-1:0] state_q;
   logic         fb;

   assign fb = ^(state_q & TAPS);

   always_ff @(posedge clk) begin
      if (rst) state_q <= SEED;
      else     state_q <= {state_q[W-2:0], fb};
   end

   assign gate_o = state_q[0];

endmodule

// File: rtl/tlb_rand_step.sv
module tlb_rand_step
   import tlb_rand_pkg::*;
#(
   parameter int unsigned IDX_W   = 4,
   parameter bit          GATE_EN = 1'b1
) (
   input  logic [IDX_W-1:0] cur_i,
   input  logic [IDX_W-1:0] limit_i,
   input  logic             wr_i,
   input  logic             gate_i,
   output logic [IDX_W-1:0] nxt_o
);

   localparam logic [IDX_W-1:0] TOP = '1;
   localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

   logic      hold_req;
   rand_act_e act;

   generate
      if (GATE_EN) begin : g_gated
         assign hold_req = gate_i;
      end else begin : g_free
         logic unused_gate;
         assign unused_gate = gate_i;
         assign hold_req    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (wr_i)                 act = ACT_TOP;
      else if (limit_i >= TOP)  act = ACT_TOP;
      else if (hold_req)        act = ACT_HOLD;
      else if (cur_i <= limit_i) act = ACT_TOP;
      else                      act = ACT_DEC;
   end

   always_comb begin
      unique case (act)
         ACT_HOLD: nxt_o = cur_i;
         ACT_DEC:  nxt_o = cur_i - ONE;
         default:  nxt_o = TOP;
      endcase
   end

endmodule

// File: rtl/tlb_rand_view.sv
module tlb_rand_view #(
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned READ_W = 32
) (
   input  logic [IDX_W-1:0]  idx_i,
   output logic [READ_W-1:0] view_o
);

   generate
      if (READ_W > IDX_W) begin : g_pad
         assign view_o = {{(READ_W-IDX_W){1'b0}}, idx_i};
      end else if (READ_W == IDX_W) begin : g_exact
         assign view_o = idx_i;
      end else begin : g_bad
         $error("tlb_rand_view: READ_W must not be below IDX_W");
         assign view_o = '0;
      end
   endgenerate

endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx #(
   parameter int unsigned      IDX_W     = 4,
   parameter int unsigned      LFSR_W    = 8,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5,
   parameter bit               GATE_EN   = 1'b1,
   parameter int unsigned      READ_W    = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  wired_i,
   input  logic              wired_we_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic [READ_W-1:0] rd_view_o
);

   localparam logic [IDX_W-1:0] TOP = '1;

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("tlb_rand_idx: IDX_W out of range");
      end
   endgenerate

   logic             lfsr_gate;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_nxt;

   tlb_rand_lfsr #(
      .W    (LFSR_W),
      .TAPS (LFSR_TAPS),
      .SEED (LFSR_SEED)
   ) u_lfsr (
      .clk    (clk),
      .rst    (rst),
      .gate_o (lfsr_gate)
   );

   tlb_rand_step #(
      .IDX_W   (IDX_W),
      .GATE_EN (GATE_EN)
   ) u_step (
      .cur_i   (idx_q),
      .limit_i (wired_i),
      .wr_i    (wired_we_i),
      .gate_i  (lfsr_gate),
      .nxt_o   (idx_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) idx_q <= TOP;
      else     idx_q <= idx_nxt;
   end

   assign idx_o = idx_q;

   tlb_rand_view #(
      .IDX_W  (IDX_W),
      .READ_W (READ_W)
   ) u_view (
      .idx_i  (idx_q),
      .view_o (rd_view_o)
   );

endmodule

// File: rtl/tlb_rand_idx_chk.sv
module tlb_rand_idx_chk #(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned READ_W  = 32,
   parameter bit          GATE_EN = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [IDX_W-1:0]  wired_i,
   input logic              wired_we_i,
   input logic [IDX_W-1:0]  idx_o,
   input logic [READ_W-1:0] rd_view_o,
   input logic              gate_bit
);

   localparam logic [IDX_W-1:0] TOP = '1;
   localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

   assert_reset_top_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> idx_o == TOP);

   // R2 and R3: one step is a hold, a single decrement or a wrap to the top
   assert_step_shape_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (idx_o == TOP || idx_o == $past(idx_o) || idx_o == $past(idx_o) - ONE));

   generate
      if (GATE_EN) begin : g_gate_chk
         assert_gate_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(gate_bit) && !$past(wired_we_i) && $past(wired_i) < TOP)
            |-> $stable(idx_o));
      end
   endgenerate

   assert_write_reload_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wired_we_i)) |-> idx_o == TOP);

   assert_pinned_top_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wired_i) >= TOP) |-> idx_o == TOP);

   assert_view_match_R7: assert property (@(posedge clk) disable iff (rst)
      rd_view_o == {{(READ_W-IDX_W){1'b0}}, idx_o});

endmodule

bind tlb_rand_idx tlb_rand_idx_chk #(
   .IDX_W   (IDX_W),
   .READ_W  (READ_W),
   .GATE_EN (GATE_EN)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wired_i    (wired_i),
   .wired_we_i (wired_we_i),
   .idx_o      (idx_o),
   .rd_view_o  (rd_view_o),
   .gate_bit   (lfsr_gate)
);

// File: tb/tb_tlb_rand_idx.sv
module tb_tlb_rand_idx;

   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  wired_i = 4'd0;
   logic        wired_we_i = 1'b0;
   logic [3:0]  idx_o;
   logic [31:0] rd_view_o;

   int checks = 0;
   int errors = 0;

   logic [3:0] m_idx;
   logic [7:0] m_lfsr;

   always #(PERIOD/2) clk = ~clk;

   tlb_rand_idx #(
      .IDX_W     (4),
      .LFSR_W    (8),
      .LFSR_TAPS (8'hB8),
      .LFSR_SEED (8'hA5),
      .GATE_EN   (1'b1),
      .READ_W    (32)
   ) dut (
      .clk        (clk),
      .rst        (rst),
      .wired_i    (wired_i),
      .wired_we_i (wired_we_i),
      .idx_o      (idx_o),
      .rd_view_o  (rd_view_o)
   );

   function automatic logic [7:0] lfsr_adv(input logic [7:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

   // Returns expected next index and names the rule that produced it
   function automatic logic [3:0] idx_next(input logic [3:0] cur, input logic [3:0] w,
                                           input logic we, input logic g, output string tag);
      if (we)            begin tag = "R5"; return 4'd15; end
      if (w >= 4'd15)    begin tag = "R6"; return 4'd15; end
      if (g)             begin tag = "R4"; return cur; end
      if (cur <= w)      begin tag = "R3"; return 4'd15; end
      tag = "R2";
      return cur - 4'd1;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive one cycle, then compare idx and view after the edge
   task automatic step(input logic [3:0] w, input logic we, input string force_tag = "");
      string tag;
      logic [3:0] exp;
      wired_i    = w;
      wired_we_i = we;
      exp    = idx_next(m_idx, w, we, m_lfsr[0], tag);
      if (force_tag != "") tag = force_tag;
      @(posedge clk);
      #1;
      m_idx  = exp;
      m_lfsr = lfsr_adv(m_lfsr);
      check(tag, {28'd0, idx_o}, {28'd0, m_idx});
      check("R7", rd_view_o, {28'd0, m_idx});
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      m_idx  = 4'd15;
      m_lfsr = 8'hA5;
      check("R1", {28'd0, idx_o}, 32'd15);
      check("R7", rd_view_o, 32'd15);
      rst = 1'b0;

      // R2/R3/R4: full sweep down to zero limit
      for (int i = 0; i < 60; i++) step(4'd0, 1'b0);
      // R3: limit in the middle, several wraps
      for (int i = 0; i < 60; i++) step(4'd9, 1'b0);
      // R6: limit at top pins the index
      for (int i = 0; i < 10; i++) step(4'd15, 1'b0);
      // R3 boundary: limit one below top
      for (int i = 0; i < 20; i++) step(4'd14, 1'b0);
      // R5: back-to-back writes
      for (int i = 0; i < 4; i++) step(4'd3, 1'b1);
      // R8: lower the limit without strobe, then raise it above the live index
      for (int i = 0; i < 30; i++) step(4'd1, 1'b0, (i == 0) ? "R8" : "");
      for (int i = 0; i < 8; i++) step(4'd12, 1'b0, "R8");

      // Mid-run reset: R1 again
      rst = 1'b1;
      @(posedge clk);
      #1;
      m_idx  = 4'd15;
      m_lfsr = 8'hA5;
      check("R1", {28'd0, idx_o}, 32'd15);
      rst = 1'b0;

      for (int i = 0; i < 3000; i++) begin
         logic [3:0] w;
         logic       we;
         w  = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 6);
         we = ($urandom % 50 == 0);
         step(w, we);
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule